// File: doc/BRIEF.md
# SDRAM Single-Command Injector

This block lets firmware place individual SDRAM commands on the command pins during device bring-up. Firmware first writes a command code into a small mode register. The next write that targets the SDRAM window is not passed on as data. It is absorbed and turned into the selected command: NOP, precharge-all, auto-refresh, mode-register load or extended-mode-register load. Every injected command needs its own absorbing write. For example, a series of refreshes takes one write for each refresh.

For mode-register loads, the bank bits and the opcode (row) field are cut out of the address of the absorbing write. The bank bits sit just above the row field, so the cut depends on a row-count setting: 13 or 14 row bits, with 10 column bits and a 32-bit data bus. The extended load always drives bank 2. After a command is injected, write-ready stays low until the command cycle and the programmed minimum spacing for that command have both passed.

When the code is zero (normal operation), writes flow straight through to the downstream controller and no command is injected.

Top module: `sdram_cmd_injector`

## Requirements
- R1: After reset the command code is 0, the pins are deselected (cs_n, ras_n, cas_n, we_n all 1), sd_clk_en is 0, and config word 2 reads 0x00020602 (defaults tRP=2, tRFC=6, tMRD=2).
- R2: Config word 0, bits [2:0], holds the command code: 0 normal, 1 NOP, 2 precharge-all, 3 mode load, 4 auto-refresh, 5 extended mode load. A write to it takes effect from the next cycle, and reading it back returns the last value written.
- R3: With code 0 and no command pending, ds_wr_valid follows mem_wr_valid, ds_wr_addr equals mem_wr_addr, mem_wr_ready follows ds_wr_ready, and the pins stay deselected.
- R4: With a nonzero code, an accepted write is never forwarded. One cycle after acceptance, {cs_n,ras_n,cas_n,we_n} carries the command for exactly one cycle: NOP 0111, precharge-all 0010 with sd_addr=0x400, refresh 0001, and either mode load 0000.
- R5: The code persists after a command, and each absorbing write injects exactly one command. Eight writes under code 4 give eight refresh cycles.
- R6: An injected NOP sets sd_clk_en, which then stays 1 until reset. No other command sets it.
- R7: For code 3, sd_ba is taken from address bits [26:25] when config word 1 bit 0 is 0 (13 rows), or from [27:26] when it is 1 (14 rows). sd_addr carries the row field, which starts at address bit 12 and is zero-extended.
- R8: For code 5, sd_ba is 2'b10 whatever the address, and sd_addr carries the row field as in R7.
- R9: Codes 6 and 7 act exactly as NOP, including the clock enable.
- R10: After an accepted command write, mem_wr_ready stays low for 1+tRP cycles for precharge, 1+tRFC for refresh, 1+tMRD for either mode load, and 1 cycle for NOP. Config word 2 holds tRP in [7:0], tRFC in [15:8] and tMRD in [23:16].
- R11: Config words 1 and 2 read back the last value written to their defined fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_addr | input | 2 | Config word select (write and read) |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for cfg_addr |
| mem_wr_valid | input | 1 | Write into the SDRAM window |
| mem_wr_addr | input | 32 | Byte address of that write |
| mem_wr_ready | output | 1 | Write accepted when high with valid |
| ds_wr_valid | output | 1 | Forwarded write to downstream controller |
| ds_wr_addr | output | 32 | Forwarded write address |
| ds_wr_ready | input | 1 | Downstream controller ready |
| sd_clk_en | output | 1 | SDRAM clock enable, sticky |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 14 | Row / opcode address |

## Verification
A spacing counter that is loaded from the wrong timing field or stops at the wrong count changes the length of the low-ready window. That is visible on mem_wr_ready within the few cycles after each absorbing write. A command code that is decoded wrongly shows on the pin pattern exactly one cycle after acceptance. A bank slice taken at the wrong position under one geometry shows as a wrong sd_ba in that same cycle. A clock enable that is lost or set too early is visible at once on sd_clk_en. A write forwarded in command mode shows on ds_wr_valid in the cycle it is presented.

// File: rtl/sdinj_pkg.sv
package sdinj_pkg;

    localparam int TIM_W = 8;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_NOP     = 3'd1,
        MODE_PREALL  = 3'd2,
        MODE_LOAD    = 3'd3,
        MODE_REFRESH = 3'd4,
        MODE_XLOAD   = 3'd5,
        MODE_RSV6    = 3'd6,
        MODE_RSV7    = 3'd7
    } inj_mode_e;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_PREALL,
        OP_REFRESH,
        OP_LOAD
    } inj_op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

    typedef struct packed {
        logic [TIM_W-1:0] t_mrd;
        logic [TIM_W-1:0] t_rfc;
        logic [TIM_W-1:0] t_rp;
    } inj_timing_t;

    localparam sd_pins_t PINS_DESEL = sd_pins_t'(4'b1111);

    function automatic inj_op_e decode_op(inj_mode_e m);
        case (m)
            MODE_PREALL:           return OP_PREALL;
            MODE_REFRESH:          return OP_REFRESH;
            MODE_LOAD, MODE_XLOAD: return OP_LOAD;
            default:               return OP_NOP;
        endcase
    endfunction

    function automatic sd_pins_t op_pins(inj_op_e op);
        case (op)
            OP_PREALL:  return sd_pins_t'(4'b0010);
            OP_REFRESH: return sd_pins_t'(4'b0001);
            OP_LOAD:    return sd_pins_t'(4'b0000);
            default:    return sd_pins_t'(4'b0111);
        endcase
    endfunction

    function automatic logic [TIM_W-1:0] op_gap(inj_op_e op, inj_timing_t t);
        case (op)
            OP_PREALL:  return t.t_rp;
            OP_REFRESH: return t.t_rfc;
            OP_LOAD:    return t.t_mrd;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/sdinj_cfg_regs.sv
module sdinj_cfg_regs
    import sdinj_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int DEF_TRP = 2,
    parameter int DEF_TRFC = 6,
    parameter int DEF_TMRD = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output inj_mode_e        mode,
    output logic             geom_wide,
    output inj_timing_t      timing
);

    localparam int TIM_BITS = 3 * TIM_W;
    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_GEOM = 2'd1;
    localparam logic [1:0] A_TIME = 2'd2;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= MODE_NORMAL;
            geom_wide    <= 1'b0;
            timing.t_rp  <= TIM_W'(DEF_TRP);
            timing.t_rfc <= TIM_W'(DEF_TRFC);
            timing.t_mrd <= TIM_W'(DEF_TMRD);
        end else if (cfg_wr_en) begin
            case (cfg_addr)
                A_MODE:  mode      <= inj_mode_e'(cfg_wdata[2:0]);
                A_GEOM:  geom_wide <= cfg_wdata[0];
                A_TIME:  timing    <= inj_timing_t'(cfg_wdata[TIM_BITS-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            A_MODE:  cfg_rdata[2:0]          = mode;
            A_GEOM:  cfg_rdata[0]            = geom_wide;
            A_TIME:  cfg_rdata[TIM_BITS-1:0] = timing;
            default: cfg_rdata = '0;
        endcase
    end

    assert_mode_update_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_addr == A_MODE) |=> (mode == $past(cfg_wdata[2:0])));

    assert_timing_update_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_addr == A_TIME) |=> (timing == $past(cfg_wdata[TIM_BITS-1:0])));

endmodule

// File: rtl/sdinj_addr_map.sv
module sdinj_addr_map #(
    parameter int ADDR_W     = 32,
    parameter int BYTE_BITS  = 2,
    parameter int COL_BITS   = 10,
    parameter int ROW_NARROW = 13,
    parameter int ROW_WIDE   = 14
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                geom_wide,
    output logic [1:0]          bank,
    output logic [ROW_WIDE-1:0] row
);

    localparam int ROW_LSB = BYTE_BITS + COL_BITS;

    logic [1:0]          bank_v [2];
    logic [ROW_WIDE-1:0] row_v  [2];

    for (genvar g = 0; g < 2; g++) begin : g_geom
        localparam int ROWS = (g == 1) ? ROW_WIDE : ROW_NARROW;
        always_comb begin
            row_v[g]           = '0;
            row_v[g][ROWS-1:0] = addr[ROW_LSB +: ROWS];
            bank_v[g]          = addr[ROW_LSB + ROWS +: 2];
        end
    end

    assign bank = geom_wide ? bank_v[1] : bank_v[0];
    assign row  = geom_wide ? row_v[1]  : row_v[0];

endmodule

// File: rtl/sdinj_cmd_seq.sv
module sdinj_cmd_seq
    import sdinj_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  inj_op_e          op,
    input  logic [1:0]       bank_in,
    input  logic [ROW_W-1:0] row_in,
    input  inj_timing_t      timing,
    output logic             busy,
    output sd_pins_t         pins,
    output logic [1:0]       sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic             clk_en
);

    localparam int AP_BIT = 10;

    logic [TIM_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            pins    <= PINS_DESEL;
            sd_ba   <= '0;
            sd_addr <= '0;
            clk_en  <= 1'b0;
        end else begin
            pins    <= PINS_DESEL;
            sd_ba   <= '0;
            sd_addr <= '0;
            if (fire) begin
                busy <= 1'b1;
                cnt  <= op_gap(op, timing);
                pins <= op_pins(op);
                case (op)
                    OP_PREALL: sd_addr[AP_BIT] <= 1'b1;
                    OP_LOAD: begin
                        sd_ba   <= bank_in;
                        sd_addr <= row_in;
                    end
                    OP_NOP:  clk_en <= 1'b1;
                    default: ;
                endcase
            end else if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end
        end
    end

    assert_fire_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        fire |-> !busy);

    assert_hold_spacing_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);

    assert_cmd_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        !pins.cs_n |=> pins.cs_n);

    assert_clk_en_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> clk_en);

endmodule

// File: rtl/sdram_cmd_injector.sv
module sdram_cmd_injector
    import sdinj_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CFG_W      = 32,
    parameter int BYTE_BITS  = 2,
    parameter int COL_BITS   = 10,
    parameter int ROW_NARROW = 13,
    parameter int ROW_WIDE   = 14,
    parameter int DEF_TRP    = 2,
    parameter int DEF_TRFC   = 6,
    parameter int DEF_TMRD   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr_en,
    input  logic [1:0]          cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic                mem_wr_valid,
    input  logic [ADDR_W-1:0]   mem_wr_addr,
    output logic                mem_wr_ready,
    output logic                ds_wr_valid,
    output logic [ADDR_W-1:0]   ds_wr_addr,
    input  logic                ds_wr_ready,
    output logic                sd_clk_en,
    output logic                sd_cs_n,
    output logic                sd_ras_n,
    output logic                sd_cas_n,
    output logic                sd_we_n,
    output logic [1:0]          sd_ba,
    output logic [ROW_WIDE-1:0] sd_addr
);

    localparam logic [1:0] XLOAD_BANK = 2'b10;

    inj_mode_e     mode;
    logic          geom_wide;
    inj_timing_t   timing;
    logic [1:0]    map_bank;
    logic [ROW_WIDE-1:0] map_row;
    logic [1:0]    cmd_bank;
    logic          busy;
    logic          normal;
    logic          fire;
    sd_pins_t      pins;

    sdinj_cfg_regs #(
        .CFG_W(CFG_W), .DEF_TRP(DEF_TRP), .DEF_TRFC(DEF_TRFC), .DEF_TMRD(DEF_TMRD)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode(mode),
        .geom_wide(geom_wide), .timing(timing)
    );

    sdinj_addr_map #(
        .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .COL_BITS(COL_BITS),
        .ROW_NARROW(ROW_NARROW), .ROW_WIDE(ROW_WIDE)
    ) u_map (
        .addr(mem_wr_addr), .geom_wide(geom_wide), .bank(map_bank), .row(map_row)
    );

    assign normal       = (mode == MODE_NORMAL);
    assign cmd_bank     = (mode == MODE_XLOAD) ? XLOAD_BANK : map_bank;
    assign mem_wr_ready = !busy && (normal ? ds_wr_ready : 1'b1);
    assign ds_wr_valid  = mem_wr_valid && !busy && normal;
    assign ds_wr_addr   = mem_wr_addr;
    assign fire         = mem_wr_valid && mem_wr_ready && !normal;

    sdinj_cmd_seq #(.ROW_W(ROW_WIDE)) u_seq (
        .clk(clk), .rst(rst), .fire(fire), .op(decode_op(mode)),
        .bank_in(cmd_bank), .row_in(map_row), .timing(timing),
        .busy(busy), .pins(pins), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .clk_en(sd_clk_en)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    assert_ready_drops_R10: assert property (@(posedge clk) disable iff (rst)
        fire |=> !mem_wr_ready);

    assert_cmd_follows_fire_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> !sd_cs_n);

    assert_forward_quiet_pins_R3: assert property (@(posedge clk) disable iff (rst)
        ds_wr_valid |-> sd_cs_n);

endmodule

// File: tb/sdram_cmd_injector_tb.sv
module sdram_cmd_injector_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_wr_valid = 1'b0;
    logic [31:0] mem_wr_addr = '0;
    logic        mem_wr_ready;
    logic        ds_wr_valid;
    logic [31:0] ds_wr_addr;
    logic        ds_wr_ready = 1'b0;
    logic        sd_clk_en, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [13:0] sd_addr;

    int checks = 0;
    int errors = 0;
    int ref_seen = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdram_cmd_injector u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_ready(mem_wr_ready),
        .ds_wr_valid(ds_wr_valid), .ds_wr_addr(ds_wr_addr), .ds_wr_ready(ds_wr_ready),
        .sd_clk_en(sd_clk_en), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    always @(negedge clk)
        if (!rst && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001) ref_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_pins(int m);
        case (m)
            2:       return 4'b0010;
            3, 5:    return 4'b0000;
            4:       return 4'b0001;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic int exp_gap(int m, int trp, int trfc, int tmrd);
        case (m)
            2:       return trp;
            4:       return trfc;
            3, 5:    return tmrd;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] exp_ba(int m, logic [31:0] a, bit wide);
        if (m == 5) return 2'b10;
        if (m == 3) return wide ? a[27:26] : a[26:25];
        return 2'b00;
    endfunction

    function automatic logic [13:0] exp_row(int m, logic [31:0] a, bit wide);
        if (m == 2) return 14'h0400;
        if (m == 3 || m == 5) return wide ? a[25:12] : {1'b0, a[24:12]};
        return 14'h0;
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // one absorbing write; returns pins, bank, row during command cycle and ready-low length
    task automatic issue(input logic [31:0] a, output logic [3:0] p, output logic [1:0] ba,
                         output logic [13:0] row, output int low, output logic fwd, output logic cs_after);
        @(negedge clk);
        mem_wr_valid = 1'b1; mem_wr_addr = a;
        #1 fwd = ds_wr_valid;
        while (!mem_wr_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        mem_wr_valid = 1'b0;
        p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        ba = sd_ba; row = sd_addr;
        low = 0;
        while (!mem_wr_ready) begin low++; @(negedge clk); end
        cs_after = sd_cs_n;
    endtask

    task automatic run_cmd(input int m, input logic [31:0] a, input bit wide,
                           input int trp, input int trfc, input int tmrd, input string req);
        logic [3:0] p; logic [1:0] ba; logic [13:0] row; int low; logic fwd; logic csa;
        issue(a, p, ba, row, low, fwd, csa);
        check({req, " R4 pins"}, {28'd0, p}, {28'd0, exp_pins(m)});
        check({req, " R4 not forwarded"}, {31'd0, fwd}, 32'd0);
        check({req, " R4 single cycle"}, {31'd0, csa}, 32'd1);
        check({req, " R10 ready-low cycles"}, low, exp_gap(m, trp, trfc, tmrd) + 1);
        if (m == 2 || m == 3 || m == 5) begin
            check({req, " R7/R8 bank"}, {30'd0, ba}, {30'd0, exp_ba(m, a, wide)});
            check({req, " R7/R8 row"}, {18'd0, row}, {18'd0, exp_row(m, a, wide)});
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int trp, trfc, tmrd, m;
        bit wide, clk_exp;
        void'($urandom(32'd20240611));
        trp = 2; trfc = 6; tmrd = 2; wide = 0; clk_exp = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cs_n", {31'd0, sd_cs_n}, 32'd1);
        check("R1 pins", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'hF);
        check("R1 clk_en", {31'd0, sd_clk_en}, 32'd0);
        cfg_read(2'd0, rd); check("R1 mode", rd, 32'd0);
        cfg_read(2'd2, rd); check("R1 timing defaults", rd, 32'h0002_0602);

        // R3 normal pass-through
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            mem_wr_valid = 1'($urandom_range(0, 1));
            ds_wr_ready  = 1'($urandom_range(0, 1));
            mem_wr_addr  = $urandom;
            #1;
            check("R3 valid", {31'd0, ds_wr_valid}, {31'd0, mem_wr_valid});
            check("R3 addr", ds_wr_addr, mem_wr_addr);
            check("R3 ready", {31'd0, mem_wr_ready}, {31'd0, ds_wr_ready});
            check("R3 no cmd", {31'd0, sd_cs_n}, 32'd1);
        end
        @(negedge clk);
        mem_wr_valid = 1'b0; ds_wr_ready = 1'b0;

        // R6: precharge first does not enable the clock
        cfg_write(2'd0, 32'd2);
        cfg_read(2'd0, rd); check("R2 readback", rd, 32'd2);
        run_cmd(2, 32'h1234_5678, wide, trp, trfc, tmrd, "prech");
        check("R6 clk_en not by precharge", {31'd0, sd_clk_en}, 32'd0);

        cfg_write(2'd0, 32'd1);
        run_cmd(1, 32'h0, wide, trp, trfc, tmrd, "nop");
        check("R6 clk_en set", {31'd0, sd_clk_en}, 32'd1);
        clk_exp = 1;

        // directed geometry corner
        cfg_write(2'd0, 32'd3);
        run_cmd(3, 32'h0200_0000, 0, trp, trfc, tmrd, "R7 geom13");
        cfg_write(2'd1, 32'd1); wide = 1;
        cfg_read(2'd1, rd); check("R11 geom readback", rd, 32'd1);
        run_cmd(3, 32'h0200_0000, 1, trp, trfc, tmrd, "R7 geom14");
        cfg_write(2'd0, 32'd5);
        run_cmd(5, 32'h0C00_3000, 1, trp, trfc, tmrd, "R8 xload");

        // R9 reserved codes behave as NOP
        cfg_write(2'd0, 32'd6);
        run_cmd(6, 32'hFFFF_FFFF, wide, trp, trfc, tmrd, "R9 code6");
        cfg_write(2'd0, 32'd7);
        run_cmd(7, 32'h0, wide, trp, trfc, tmrd, "R9 code7");

        // random mix
        for (int i = 0; i < 40; i++) begin
            trp = $urandom_range(0, 12); trfc = $urandom_range(0, 12); tmrd = $urandom_range(0, 12);
            cfg_write(2'd2, {8'd0, 8'(tmrd), 8'(trfc), 8'(trp)});
            cfg_read(2'd2, rd);
            check("R11 timing readback", rd, {8'd0, 8'(tmrd), 8'(trfc), 8'(trp)});
            wide = 1'($urandom_range(0, 1));
            cfg_write(2'd1, {31'd0, wide});
            m = $urandom_range(1, 7);
            cfg_write(2'd0, m);
            cfg_read(2'd0, rd); check("R2 mode readback", rd, m);
            run_cmd(m, $urandom, wide, trp, trfc, tmrd, "random");
            check("R6 clk_en sticky", {31'd0, sd_clk_en}, {31'd0, clk_exp});
        end

        // R5 eight refreshes need eight writes
        cfg_write(2'd0, 32'd4);
        @(negedge clk);
        ref_seen = 0;
        for (int i = 0; i < 8; i++)
            run_cmd(4, $urandom, wide, trp, trfc, tmrd, "R5 refresh");
        repeat (3) @(negedge clk);
        check("R5 refresh count", ref_seen, 8);
        cfg_read(2'd0, rd); check("R5 code persists", rd, 32'd4);

        // back to normal: forwarding resumes
        cfg_write(2'd0, 32'd0);
        ds_wr_ready = 1'b1; mem_wr_valid = 1'b1; mem_wr_addr = 32'hA5A5_0000;
        #1;
        check("R3 forward after cmds", {31'd0, ds_wr_valid}, 32'd1);
        check("R6 clk_en still set", {31'd0, sd_clk_en}, 32'd1);
        @(negedge clk);
        mem_wr_valid = 1'b0;

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule